// File: doc/BRIEF.md
# Dual-Mode PWM Timer with Dead-Time

This block is one PWM timer channel. A free-running counter is compared against a compare value to make a raw pulse train. The counter either climbs and wraps to zero (edge-aligned) or climbs to the period value and then falls back (centre-aligned). For the same period value, the centre-aligned form runs at half the frequency of the edge-aligned form. Matching the edge-aligned frequency means halving the period count, which costs duty resolution.

The raw signal drives two outputs for a half-bridge power stage: a main output and its complement. Each output turns on only a programmable number of clock cycles after its drive request rises, so the two are never on together. An output whose pulse is shorter than the dead-time stays off for that pulse.

Software writes period, compare, alignment and dead-time into shadow registers through a four-word register port. The shadow values move into the working set only at the count-zero point, so a period never mixes old and new settings. A one-cycle start pulse marks each new period, for a dither sequencer or similar logic to advance on.

Top module: `pwm_deadtime_timer`

## Requirements
- R1: In edge-aligned mode, with period P, the count runs 0,1,…,P and returns to 0, so one period is P+1 cycles. For 0 < compare < P and dead-time 0, the main output is high for `compare` cycles of each period.
- R2: In centre-aligned mode, the count runs 0,1,…,P,P-1,…,1 and then 0 again, so one period is 2P cycles. The count changes by exactly one each cycle. The raw signal is high while count < compare, which gives 2·compare−1 high cycles per period when 0 < compare < P.
- R3: A compare value of 0 holds the main output low and the complementary output high, whatever the period.
- R4: A compare value at or above the period (and non-zero) holds the main output high and the complementary output low.
- R5: The main and complementary outputs are never high in the same cycle.
- R6: Each output rises a number of cycles after its drive request rises equal to the dead-time, and falls at once. A pulse of length L yields max(0, L − dead-time) high cycles. A dead-time of 2 or more leaves the complementary output low in the cycle after the main output falls.
- R7: Register writes land in shadow storage and take effect only after the counter next passes through 0. The rest of the running period keeps the old values.
- R8: The start output is high for exactly one cycle in every period.
- R9: While reset is held, all outputs are low. After reset, the working settings are: period 2^CNT_W−1, compare 0, edge-aligned, dead-time 0.
- R10: The register address selects the field. Address 0 is the period and address 1 is the compare value. Address 2 is the alignment: data bit 0, where 0 is edge-aligned and 1 is centre-aligned. Address 3 is the dead-time, taken from data bits DT_W−1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | CNT_W | Write data |
| pwm_main_o | output | 1 | Main PWM output |
| pwm_comp_o | output | 1 | Complementary PWM output |
| cycle_start_o | output | 1 | One-cycle pulse at each period start |

## Verification
The single-cycle start-pulse property assumes the period is at least 1. With period 0 the counter sits at zero and the pulse would stay high, so the stimulus never writes a period below 2. The dead-time gap property is conditioned on the dead-time being unchanged across the cycle it inspects, because a reload may coincide with an output edge. Writes are issued away from clock edges, and every measured window is preceded by enough idle cycles that the new settings have loaded and the outputs have reached steady state.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic {
    ALIGN_EDGE   = 1'b0,
    ALIGN_CENTRE = 1'b1
  } align_e;

  localparam logic [1:0] REG_PERIOD  = 2'd0;
  localparam logic [1:0] REG_COMPARE = 2'd1;
  localparam logic [1:0] REG_ALIGN   = 2'd2;
  localparam logic [1:0] REG_DEAD    = 2'd3;
endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             load,
  output logic [CNT_W-1:0] per_a,
  output logic [CNT_W-1:0] cmp_a,
  output align_e           mode_a,
  output logic [DT_W-1:0]  dt_a
);
  localparam logic [CNT_W-1:0] PER_RST = '1;

  logic [CNT_W-1:0] per_s, cmp_s;
  align_e           mode_s;
  logic [DT_W-1:0]  dt_s;

  // shadow side: written at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      per_s  <= PER_RST;
      cmp_s  <= '0;
      mode_s <= ALIGN_EDGE;
      dt_s   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_PERIOD:  per_s  <= wr_data;
        REG_COMPARE: cmp_s  <= wr_data;
        REG_ALIGN:   mode_s <= align_e'(wr_data[0]);
        default:     dt_s   <= wr_data[DT_W-1:0];
      endcase
    end
  end

  // working side: copied only at the count-zero point
  always_ff @(posedge clk) begin
    if (rst) begin
      per_a  <= PER_RST;
      cmp_a  <= '0;
      mode_a <= ALIGN_EDGE;
      dt_a   <= '0;
    end else if (load) begin
      per_a  <= per_s;
      cmp_a  <= cmp_s;
      mode_a <= mode_s;
      dt_a   <= dt_s;
    end
  end
endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  input  align_e           mode,
  output logic [CNT_W-1:0] cnt,
  output logic             at_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic going_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      going_up <= 1'b1;
    end else if (mode == ALIGN_EDGE) begin
      going_up <= 1'b1;
      cnt      <= (cnt >= period) ? '0 : cnt + ONE;
    end else if (going_up) begin
      if (cnt >= period) begin
        going_up <= 1'b0;
        cnt      <= (period == '0) ? '0 : cnt - ONE;
      end else begin
        cnt <= cnt + ONE;
      end
    end else begin
      if (cnt == '0) begin
        going_up <= 1'b1;
        cnt      <= (period == '0) ? '0 : ONE;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  assign at_zero = (cnt == '0);
endmodule

// File: rtl/pwm_dead_gate.sv
module pwm_dead_gate #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            want,
  input  logic [DT_W-1:0] dead,
  output logic            drive_o
);
  logic [DT_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst || !want) begin
      drive_o  <= 1'b0;
      wait_cnt <= '0;
    end else if (wait_cnt >= dead) begin
      drive_o <= 1'b1;
    end else begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_deadtime_timer.sv
module pwm_deadtime_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_main_o,
  output logic             pwm_comp_o,
  output logic             cycle_start_o
);
  localparam int N_OUT = 2;

  logic [CNT_W-1:0] per_a, cmp_a, cnt;
  align_e           mode_a;
  logic [DT_W-1:0]  dt_a;
  logic             at_zero;
  logic             raw_q;
  logic [N_OUT-1:0] want, drive;

  pwm_shadow_bank #(.CNT_W(CNT_W), .DT_W(DT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(at_zero), .per_a(per_a), .cmp_a(cmp_a), .mode_a(mode_a), .dt_a(dt_a)
  );

  pwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .period(per_a), .mode(mode_a),
    .cnt(cnt), .at_zero(at_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q         <= 1'b0;
      cycle_start_o <= 1'b0;
    end else begin
      cycle_start_o <= at_zero;
      if (cmp_a == '0)         raw_q <= 1'b0;
      else if (cmp_a >= per_a) raw_q <= 1'b1;
      else                     raw_q <= (cnt < cmp_a);
    end
  end

  assign want[0] = raw_q;
  assign want[1] = ~raw_q;

  for (genvar g = 0; g < N_OUT; g++) begin : g_gate
    pwm_dead_gate #(.DT_W(DT_W)) u_gate (
      .clk(clk), .rst(rst), .want(want[g]), .dead(dt_a), .drive_o(drive[g])
    );
  end

  assign pwm_main_o = drive[0];
  assign pwm_comp_o = drive[1];
endmodule

// File: rtl/pwm_deadtime_checker.sv
module pwm_deadtime_checker #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pwm_main_o,
  input logic             pwm_comp_o,
  input logic             cycle_start_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_a,
  input logic [CNT_W-1:0] cmp_a,
  input logic             mode_a,
  input logic [DT_W-1:0]  dt_a
);
  a_r1_edge_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$past(mode_a) && ($past(cnt) >= $past(per_a))) |-> (cnt == '0));

  a_r2_centre_step: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_a) && ($past(per_a) != '0)) |->
      (({1'b0, cnt} == {1'b0, $past(cnt)} + 1'b1) ||
       ({1'b0, cnt} + 1'b1 == {1'b0, $past(cnt)})));

  a_r3_zero_compare_low: assert property (@(posedge clk) disable iff (rst)
    ($past(cmp_a, 2) == '0) |-> !pwm_main_o);

  a_r5_never_both: assert property (@(posedge clk) disable iff (rst)
    !(pwm_main_o && pwm_comp_o));

  a_r6_dead_gap: assert property (@(posedge clk) disable iff (rst)
    ($fell(pwm_main_o) && (dt_a > DT_W'(1)) && $stable(dt_a)) |=> !pwm_comp_o);

  a_r8_start_single: assert property (@(posedge clk) disable iff (rst)
    cycle_start_o |=> !cycle_start_o);
endmodule

bind pwm_deadtime_timer pwm_deadtime_checker #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
  .clk(clk), .rst(rst), .pwm_main_o(pwm_main_o), .pwm_comp_o(pwm_comp_o),
  .cycle_start_o(cycle_start_o), .cnt(cnt), .per_a(per_a), .cmp_a(cmp_a),
  .mode_a(mode_a), .dt_a(dt_a)
);

// File: tb/sim_pwm_deadtime_timer.sv
`timescale 1ns/1ps
module sim_pwm_deadtime_timer;
  localparam int CNT_W = 8;
  localparam int DT_W  = 4;
  localparam int K     = 4;
  localparam int NV    = 13;

  // {mode, period, compare, dead, main-high per period, comp-high per period}
  localparam logic [47:0] VEC [NV] = '{
    {8'd0, 8'd9,  8'd4,   8'd0, 8'd4,  8'd6},   // R1
    {8'd0, 8'd9,  8'd4,   8'd2, 8'd2,  8'd4},   // R1 R6
    {8'd0, 8'd15, 8'd12,  8'd1, 8'd11, 8'd3},   // R1 R6
    {8'd0, 8'd9,  8'd2,   8'd3, 8'd0,  8'd5},   // R6 short pulse
    {8'd0, 8'd9,  8'd0,   8'd1, 8'd0,  8'd10},  // R3
    {8'd0, 8'd9,  8'd9,   8'd2, 8'd10, 8'd0},   // R4
    {8'd0, 8'd9,  8'd200, 8'd0, 8'd10, 8'd0},   // R4
    {8'd1, 8'd8,  8'd3,   8'd0, 8'd5,  8'd11},  // R2
    {8'd1, 8'd8,  8'd3,   8'd2, 8'd3,  8'd9},   // R2 R6
    {8'd1, 8'd10, 8'd1,   8'd0, 8'd1,  8'd19},  // R2
    {8'd1, 8'd6,  8'd6,   8'd1, 8'd12, 8'd0},   // R4
    {8'd1, 8'd6,  8'd0,   8'd3, 8'd0,  8'd12},  // R3
    {8'd1, 8'd5,  8'd4,   8'd4, 8'd3,  8'd0}    // R2 R6
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic pwm_main_o, pwm_comp_o, cycle_start_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int m_hi, c_hi, s_hi, both_hi;

  always #2.5 clk = ~clk;

  pwm_deadtime_timer #(.CNT_W(CNT_W), .DT_W(DT_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_main_o(pwm_main_o), .pwm_comp_o(pwm_comp_o), .cycle_start_o(cycle_start_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n);
    m_hi = 0; c_hi = 0; s_hi = 0; both_hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      m_hi += int'(pwm_main_o);
      c_hi += int'(pwm_comp_o);
      s_hi += int'(cycle_start_o);
      both_hi += int'(pwm_main_o && pwm_comp_o);
    end
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!cycle_start_o);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: outputs low while reset is held
    idle(4);
    check("R9 main in reset", int'(pwm_main_o), 0);
    check("R9 comp in reset", int'(pwm_comp_o), 0);
    check("R9 start in reset", int'(cycle_start_o), 0);
    rst = 1'b0;

    // R9: defaults give compare 0, period 255 (256 cycles), edge, no dead-time
    idle(10);
    measure(512);
    check("R9 default main", m_hi, 0);
    check("R9 default comp", c_hi, 512);
    check("R9 default start", s_hi, 2);

    // table of settings, each measured over K whole periods
    for (int v = 0; v < NV; v++) begin
      logic [7:0] md, pr, cp, dt, em, ec;
      int plen;
      string lbl;
      {md, pr, cp, dt, em, ec} = VEC[v];
      wr(2'd0, pr);          // R10 address 0 = period
      wr(2'd1, cp);          // R10 address 1 = compare
      wr(2'd2, md);          // R10 address 2 bit0 = alignment
      wr(2'd3, dt);          // R10 address 3 = dead-time
      plen = (md[0]) ? 2 * int'(pr) : int'(pr) + 1;
      idle(600);
      measure(K * plen);
      if (cp == 0)       lbl = "R3";
      else if (cp >= pr) lbl = "R4";
      else if (md[0])    lbl = "R2";
      else               lbl = "R1";
      check($sformatf("%s vec%0d main high", lbl, v), m_hi, K * int'(em));
      check($sformatf("R6 %s vec%0d comp high", lbl, v), c_hi, K * int'(ec));
      check($sformatf("R8 R10 vec%0d start pulses", v), s_hi, K);
      check($sformatf("R5 vec%0d overlap", v), both_hi, 0);
    end

    // R7: compare write mid-period leaves the running period alone
    wr(2'd2, 8'd0);
    wr(2'd3, 8'd0);
    wr(2'd0, 8'd200);
    wr(2'd1, 8'd100);
    idle(700);
    wait_start();
    idle(20);
    wr(2'd1, 8'd10);
    idle(30);
    check("R7 old compare still active", int'(pwm_main_o), 1);
    wait_start();
    idle(40);
    check("R7 new compare after boundary", int'(pwm_main_o), 0);
    check("R7 comp follows new compare", int'(pwm_comp_o), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule